// File: doc/BRIEF.md
# Serial Management Interface Slave

This block is the slave end of a two-wire serial management link (clause-22 framing). It samples the data line on every rising edge of the management clock. It finds the start of a frame, collects a 12-bit header, and then either returns a 16-bit register value or takes in a 16-bit value for a register. The register file sits outside the block. The block reaches it through an address, a write-data word, a write strobe, a read strobe and a read-data word, which is returned combinationally.

The bidirectional data line is split into an input, an output and an output enable, so that a pad cell or a board-level model can combine them. The block serves one device only, so the device-address field of the header is received and then dropped. When a frame is malformed, the block goes back to looking for a start and performs no register access.

Top module: `mdio_slave`

## Requirements
- R1: While idle, a sampled 1 is ignored, so a preamble of any length (including none) is accepted. A sampled 0 arms the start detector. While armed, further 0s keep it armed, and the first 1 begins the header.
- R2: The header is 12 bits, received most significant bit first. Its fields are the 2-bit opcode first, then a 5-bit device address, then the 5-bit register address. The device address has no effect on any access.
- R3: Read opcode is binary 10. On the clock edge that samples the last header bit, the block enters a single turnaround cycle. In that cycle `reg_re_o` is 1 for exactly one cycle, `reg_addr_o` holds the register address, and the block drives the line to 0 with `mdio_oe_o` at 1.
- R4: After the read turnaround, the fetched value is driven most significant bit first, one bit per cycle, for exactly 16 cycles. The line is then released. Values sampled on `mdio_i` during a read have no effect.
- R5: Write opcode is binary 01. The two bits after the header are skipped, whatever their values. The next 16 bits are the data, most significant bit first. In the cycle after the 16th data bit is sampled, `reg_we_o` is 1 for one cycle, with `reg_addr_o` and `reg_wdata_o` carrying the address and the data.
- R6: Opcodes 00 and 11 end the frame after the header. No read strobe and no write strobe is produced, the line stays released, and the block returns to idle.
- R7: `mdio_oe_o` is 1 only during the read turnaround and the read data cycles. Whenever `mdio_oe_o` is 0, `mdio_o` is 0.
- R8: An asynchronous active-low reset returns the block to idle at once. It releases the line and clears both strobes, even in the middle of a frame.
- R9: `reg_we_o` and `reg_re_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Management clock; the line is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Sampled value of the data line |
| mdio_o | output | 1 | Value to drive on the data line |
| mdio_oe_o | output | 1 | Drive enable for the data line |
| reg_addr_o | output | 5 | Register address of the current access |
| reg_wdata_o | output | 16 | Write data, valid while `reg_we_o` is 1 |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle read strobe; read data is captured in the same cycle |
| reg_rdata_i | input | 16 | Register value for `reg_addr_o`, returned combinationally |

## Verification
A wrong frame state appears at the pins within one bit time. The drive enable rises or falls at the wrong cycle, a strobe is missing or doubled, or the returned word comes back shifted by one bit. The bench checks the turnaround cycle and all 16 data cycles of every read frame. It counts strobes across frames with invalid opcodes, so a decoder that acts on a bad opcode shows up as a stray write or a changed read-back. A miscounted header or turnaround length misaligns the address or data, and the read-back of a later register reveals it.

// File: rtl/mdio_slave_pkg.sv
`timescale 1ns/1ps
package mdio_slave_pkg;
  localparam int OP_W = 2;
  localparam int TA_W = 2;  // write turnaround bits skipped
  localparam logic [OP_W-1:0] OP_RD = 2'b10;
  localparam logic [OP_W-1:0] OP_WR = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HDR,
    ST_RD_TA,
    ST_WR_TA,
    ST_RD_DATA,
    ST_WR_DATA
  } frame_state_e;
endpackage

// File: rtl/mdio_shift_reg.sv
`timescale 1ns/1ps
module mdio_shift_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] load_val_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (clr_i)   q_q <= '0;
    else if (load_i)  q_q <= load_val_i;
    else if (shift_i) q_q <= {q_q[W-2:0], bit_i};
  end

  assign q_o = q_q;
endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
  import mdio_slave_pkg::*;
#(
  parameter int HDR_W  = 12,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bit_i,
  input  logic [OP_W-1:0] op_i,
  output frame_state_e    state_o,
  output logic            clr_o,
  output logic            load_o,
  output logic            shift_o,
  output logic            addr_load_o,
  output logic            wr_done_o
);
  frame_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic last;

  assign last = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (!bit_i) state_q <= ST_START;
        ST_START: if (bit_i) begin
          state_q <= ST_HDR;
          cnt_q   <= CNT_W'(HDR_W);
        end
        ST_HDR: begin
          if (last) begin
            if (op_i == OP_RD) begin
              state_q <= ST_RD_TA;
            end else if (op_i == OP_WR) begin
              state_q <= ST_WR_TA;
              cnt_q   <= CNT_W'(TA_W);
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_RD_TA: begin
          state_q <= ST_RD_DATA;
          cnt_q   <= CNT_W'(DATA_W);
        end
        ST_WR_TA: begin
          if (last) begin
            state_q <= ST_WR_DATA;
            cnt_q   <= CNT_W'(DATA_W);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_RD_DATA, ST_WR_DATA: begin
          if (last) state_q <= ST_IDLE;
          else      cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    clr_o       = (state_q == ST_START) && bit_i;
    load_o      = (state_q == ST_RD_TA);
    shift_o     = (state_q == ST_HDR) || (state_q == ST_WR_DATA) || (state_q == ST_RD_DATA);
    addr_load_o = (state_q == ST_HDR) && last && ((op_i == OP_RD) || (op_i == OP_WR));
    wr_done_o   = (state_q == ST_WR_DATA) && last;
  end

  assign state_o = state_q;
endmodule

// File: rtl/mdio_reg_port.sv
`timescale 1ns/1ps
module mdio_reg_port #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_load_i,
  input  logic [REG_AW-1:0] addr_val_i,
  input  logic              wr_done_i,
  input  logic [DATA_W-1:0] wdata_val_i,
  input  logic              rd_fetch_i,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o
);
  logic [REG_AW-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else begin
      if (addr_load_i) addr_q <= addr_val_i;
      if (wr_done_i)   wdata_q <= wdata_val_i;
      we_q <= wr_done_i;
    end
  end

  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_we_o    = we_q;
  assign reg_re_o    = rd_fetch_i;
endmodule

// File: rtl/mdio_slave.sv
`timescale 1ns/1ps
module mdio_slave
  import mdio_slave_pkg::*;
#(
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int HDR_W   = OP_W + PHY_AW + REG_AW;
  localparam int CNT_MAX = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  frame_state_e state;
  logic [DATA_W-1:0] acc;
  logic clr, load, shift, addr_load, wr_done;
  logic [OP_W-1:0]   op;
  logic [REG_AW-1:0] addr_val;

  // acc holds the first HDR_W-1 header bits when the last one arrives
  assign op       = acc[HDR_W-2 -: OP_W];
  assign addr_val = {acc[REG_AW-2:0], mdio_i};

  mdio_frame_fsm #(
    .HDR_W (HDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_i      (mdio_i),
    .op_i       (op),
    .state_o    (state),
    .clr_o      (clr),
    .load_o     (load),
    .shift_o    (shift),
    .addr_load_o(addr_load),
    .wr_done_o  (wr_done)
  );

  mdio_shift_reg #(.W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .load_i    (load),
    .shift_i   (shift),
    .load_val_i(reg_rdata_i),
    .bit_i     (mdio_i),
    .q_o       (acc)
  );

  mdio_reg_port #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_load_i(addr_load),
    .addr_val_i (addr_val),
    .wr_done_i  (wr_done),
    .wdata_val_i({acc[DATA_W-2:0], mdio_i}),
    .rd_fetch_i (load),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_we_o   (reg_we_o),
    .reg_re_o   (reg_re_o)
  );

  assign mdio_oe_o = (state == ST_RD_TA) || (state == ST_RD_DATA);
  assign mdio_o    = (state == ST_RD_DATA) && acc[DATA_W-1];
endmodule

// File: rtl/mdio_slave_chk.sv
`timescale 1ns/1ps
module mdio_slave_chk #(
  parameter int DATA_W = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic mdio_o,
  input logic mdio_oe_o,
  input logic reg_we_o,
  input logic reg_re_o
);
  localparam int OE_CYC = DATA_W + 1;
  localparam int OC_W   = $clog2(OE_CYC + 2);
  logic [OC_W-1:0] oe_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        oe_cnt_q <= '0;
    else if (mdio_oe_o) oe_cnt_q <= oe_cnt_q + 1'b1;
    else                oe_cnt_q <= '0;
  end

  // R3
  rd_ta_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |-> (mdio_oe_o && !mdio_o));
  // R3
  rd_strobe_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> (!reg_re_o && mdio_oe_o));
  // R4
  rd_window_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdio_oe_o) |-> (oe_cnt_q == OC_W'(OE_CYC)));
  // R5
  wr_strobe_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  // R7
  oe_starts_at_ta_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> reg_re_o);
  // R7
  released_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mdio_oe_o |-> !mdio_o);
  // R9
  no_dual_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));
endmodule

bind mdio_slave mdio_slave_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_mdio_slave.sv
`timescale 1ns/1ps
module tb_mdio_slave;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int NREG = 1 << AW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mdio_i = 1'b1;
  logic mdio_o, mdio_oe_o, reg_we_o, reg_re_o;
  logic [AW-1:0] reg_addr_o;
  logic [DW-1:0] reg_wdata_o, reg_rdata_i;

  logic [DW-1:0] rf  [NREG];
  logic [DW-1:0] exp_rf [NREG];
  int we_cnt = 0, re_cnt = 0;
  int errors = 0, checks = 0;

  always #2 clk_i = ~clk_i;

  mdio_slave dut (.*);

  assign reg_rdata_i = rf[reg_addr_o];

  always @(posedge clk_i) begin
    if (reg_we_o) begin
      rf[reg_addr_o] <= reg_wdata_o;
      we_cnt <= we_cnt + 1;
    end
    if (reg_re_o) re_cnt <= re_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk_i);
    mdio_i = b;
  endtask

  task automatic send_pre(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  // start: nz zeros then a one, then 12 header bits
  task automatic send_hdr(input int nz, input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
    logic [11:0] h;
    h = {op, phy, ra};
    for (int i = 0; i < nz; i++) send_bit(1'b0);
    send_bit(1'b1);
    for (int i = 11; i >= 0; i--) send_bit(h[i]);
  endtask

  task automatic do_write(input int pre, input int nz, input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] v, input logic [1:0] ta);
    send_pre(pre);
    send_hdr(nz, 2'b01, phy, ra);
    send_bit(ta[1]);
    send_bit(ta[0]);
    for (int i = 15; i >= 0; i--) send_bit(v[i]);
    @(negedge clk_i);
    mdio_i = 1'b1;
    chk(reg_we_o === 1'b1, "R5 write strobe", reg_we_o, 1);
    chk(reg_addr_o === ra, "R2 R5 write address", reg_addr_o, ra);
    chk(reg_wdata_o === v, "R5 write data", reg_wdata_o, v);
    chk(reg_re_o === 1'b0, "R9 no read strobe on write", reg_re_o, 0);
    exp_rf[ra] = v;
    @(negedge clk_i);
    chk(reg_we_o === 1'b0, "R5 write strobe one cycle", reg_we_o, 0);
  endtask

  task automatic do_read(input int pre, input int nz, input logic [4:0] phy, input logic [4:0] ra,
                         input logic host_bit);
    logic [15:0] got;
    bit oe_all;
    send_pre(pre);
    send_hdr(nz, 2'b10, phy, ra);
    @(negedge clk_i);
    mdio_i = host_bit;
    chk(reg_re_o === 1'b1 && reg_addr_o === ra, "R3 read strobe and address", {reg_re_o, 3'b0, reg_addr_o}, {1'b1, 3'b0, ra});
    chk(mdio_oe_o === 1'b1 && mdio_o === 1'b0, "R3 turnaround drives 0", {mdio_oe_o, mdio_o}, 2'b10);
    got = '0;
    oe_all = 1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      mdio_i = host_bit;
      got = {got[14:0], mdio_o};
      if (mdio_oe_o !== 1'b1) oe_all = 0;
    end
    chk(oe_all, "R4 enable held 16 data cycles", oe_all, 1);
    chk(got === exp_rf[ra], "R4 read data MSB first", got, exp_rf[ra]);
    @(negedge clk_i);
    mdio_i = 1'b1;
    chk(mdio_oe_o === 1'b0 && mdio_o === 1'b0, "R4 R7 released after read", {mdio_oe_o, mdio_o}, 0);
  endtask

  task automatic bad_op(input logic [1:0] op, input logic [4:0] ra);
    int w0, r0;
    bit oe_seen;
    w0 = we_cnt;
    r0 = re_cnt;
    oe_seen = 0;
    send_pre(32);
    send_hdr(1, op, 5'h00, ra);
    for (int i = 0; i < 24; i++) begin
      send_bit(1'b1);
      if (mdio_oe_o !== 1'b0) oe_seen = 1;
    end
    chk(we_cnt == w0 && re_cnt == r0, "R6 no access on bad opcode", we_cnt + re_cnt, w0 + r0);
    chk(!oe_seen, "R6 R7 line released on bad opcode", oe_seen, 0);
  endtask

  task automatic t_reset;
    chk(mdio_oe_o === 1'b0 && mdio_o === 1'b0, "R8 reset releases line", {mdio_oe_o, mdio_o}, 0);
    chk(reg_we_o === 1'b0 && reg_re_o === 1'b0, "R8 reset clears strobes", {reg_we_o, reg_re_o}, 0);
  endtask

  task automatic t_reset_mid_read;
    send_pre(32);
    send_hdr(1, 2'b10, 5'h02, 5'd9);
    repeat (5) send_bit(1'b1);
    chk(mdio_oe_o === 1'b1, "R4 driving before reset", mdio_oe_o, 1);
    #1 rst_ni = 1'b0;
    #0.5;
    chk(mdio_oe_o === 1'b0 && mdio_o === 1'b0, "R8 async reset releases mid-frame", {mdio_oe_o, mdio_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    do_read(32, 1, 5'h02, 5'd9, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) begin
      rf[i] = 16'(i * 16'h0101 + 16'h1357);
      exp_rf[i] = rf[i];
    end
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    // R5 R4 basic write and read back
    do_write(32, 1, 5'h01, 5'd3, 16'hA5C3, 2'b10);
    do_read(32, 1, 5'h01, 5'd3, 1'b1);
    // R4 reset contents, edge addresses, extreme values
    do_read(32, 1, 5'h01, 5'd17, 1'b1);
    do_write(32, 1, 5'h01, 5'd0, 16'hFFFF, 2'b01);
    do_write(32, 1, 5'h01, 5'd31, 16'h0000, 2'b11);
    do_read(32, 1, 5'h01, 5'd0, 1'b1);
    do_read(32, 1, 5'h01, 5'd31, 1'b1);
    // R2 device address ignored
    do_write(32, 1, 5'h1F, 5'd12, 16'h8001, 2'b00);
    do_read(32, 1, 5'h00, 5'd12, 1'b1);
    // R1 no preamble and several start zeros
    do_write(0, 4, 5'h05, 5'd20, 16'h3C5A, 2'b10);
    do_read(0, 3, 5'h0A, 5'd20, 1'b1);
    // R4 host driving 0 during read has no effect
    do_read(32, 1, 5'h01, 5'd3, 1'b0);
    do_read(32, 1, 5'h01, 5'd3, 1'b1);
    // R6 invalid opcodes
    bad_op(2'b00, 5'd3);
    bad_op(2'b11, 5'd12);
    do_read(32, 1, 5'h01, 5'd3, 1'b1);
    do_read(32, 1, 5'h01, 5'd12, 1'b1);
    // R8 reset mid-frame
    t_reset_mid_read();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule